// File: doc/BRIEF.md
# Dual Smart-Card Channel Router

This block connects one host-side card interface (a reset level, a card clock and an open-drain data line) to one of two smart-card channels. A single select input picks which channel talks to the host. Each channel also has its own enable, supply-level request and clock-run control, plus a ready input from a separate power-sequencing block. Analog level shifting, pull-up sources, regulators and the activation and deactivation timing are outside this block. The block only sees logic levels and drive enables.

Channels stay powered while they are not selected. A deselected channel keeps its reset level frozen, so the card does not need to be initialised again when it is selected later. Its clock either stops cleanly at a host clock boundary or keeps running when its clock-run input is set. The data path is modelled as a wired-AND. A low seen on one side of the selected path is copied onto the other side. A small direction state stops the block from answering its own copied low. Everything runs on the system clock `clk`. The host card clock is a slower signal that the block oversamples.

Top module: `dual_card_router`

## Requirements
- R1: A channel is selected when `chan_sel` equals its index (0 for channel A, 1 for channel B). A channel is live when both its enable and its ready bits are 1. If the selected channel is live, a host data low (`host_dat_in`=0) sets that channel's `card_dat_oe` to 1 (1 means "pull the line low") one clock later. A low on the selected card's line instead sets `host_dat_oe` to 1 one clock later. Each copied low is removed once the driving side releases.
- R2: A live channel that is not selected has `card_dat_oe`=0, so its line rests high. A low on its line never reaches `host_dat_oe`.
- R3: A live, selected channel's `card_rst` equals `host_rst` delayed by one clock.
- R4: A live, deselected channel's `card_rst` keeps the value it had when it was deselected, whatever `host_rst` does. It follows `host_rst` again once the channel is selected again.
- R5: A live channel passes the host clock (delayed by one clock) on `card_clk` when it is selected, or when its clock-run bit is 1 whether or not it is selected.
- R6: A live, deselected channel whose clock-run bit is 0 has `card_clk` held low within two host clock periods of losing selection.
- R7: The per-channel clock gate changes only at a falling edge of the host clock. So every `card_clk` high pulse lasts exactly one full host clock high phase. Also, `card_clk` is high only when the host clock was high one clock earlier.
- R8: A channel that is not live drives `card_rst`=0, `card_clk`=0 and `card_dat_oe`=1, one clock after it stops being live. This overrides selection and clock-run.
- R9: Each channel reports a 2-bit supply code in `card_vcode[2c+1:2c]`, one clock after its inputs. The code is 00 when the channel is disabled. When enabled, it is 01 for the 1.8 V level (`chan_vsel`=0) and 10 for the 3 V level (`chan_vsel`=1). The code does not depend on selection or ready.
- R10: When neither channel is enabled, `host_dat_oe` is 0, so the host line reads high.
- R11: While the block copies a host low to the card, the resulting card low is not returned to the host, and the reverse also holds. If both sides go low together while the path is idle, the host wins. After a release, the path is idle again within two clocks.
- R12: While `rst_n` is low, at a clock edge the block sets `card_rst`=0, `card_clk`=0, `host_dat_oe`=0, `card_vcode`=0 and `card_dat_oe`=all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the host card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sel | input | SELW | Index of the channel connected to the host |
| chan_en | input | NCH | Per-channel enable |
| chan_rdy | input | NCH | Per-channel ready from the power sequencer |
| chan_vsel | input | NCH | Per-channel supply request: 1 is 3 V, 0 is 1.8 V |
| chan_clkrun | input | NCH | Per-channel: keep the clock running when deselected |
| host_clk | input | 1 | Host card clock, oversampled by clk |
| host_rst | input | 1 | Host card reset level |
| host_dat_in | input | 1 | Level of the host data line |
| host_dat_oe | output | 1 | Pull the host data line low |
| card_clk | output | NCH | Per-channel gated card clock |
| card_rst | output | NCH | Per-channel card reset level |
| card_dat_in | input | NCH | Level of each card data line |
| card_dat_oe | output | NCH | Per-channel: pull the card data line low |
| card_vcode | output | 2*NCH | Per-channel supply-level code |

## Verification
The clock gating and supply codes are swept over every combination of select, enable, clock-run and supply request. This separates the selected, clock-run and stopped clock cases, and the three supply codes. The select change is repeated at every phase of the host clock, and the length of each card clock pulse is measured. This shows whether the gate ever cuts a pulse short and whether the stopped clock goes low in time. Reset is checked by toggling the host reset around selection changes. A frozen level on the deselected channel is then easy to tell apart from a level that follows the host. The data path is driven from the host side, from the selected card, from the unselected card and from both sides at once. This tells apart correct direction, isolation, host priority and freedom from latch-up.

// File: rtl/card_router_pkg.sv
// Package: shared constants and types for the dual card router.
// Assumes two channels; the selector width is derived from the count.
package card_router_pkg;

    localparam int NCH_DEF = 2;
    localparam int VCW     = 2;

    // Supply-level code reported per channel
    typedef enum logic [VCW-1:0] {
        VC_OFF  = 2'b00,
        VC_LOW  = 2'b01,
        VC_HIGH = 2'b10
    } vcode_t;

    // Direction state of the shared data path
    typedef enum logic [1:0] {
        DP_IDLE = 2'b00,
        DP_H2C  = 2'b01,
        DP_C2H  = 2'b10,
        DP_REL  = 2'b11
    } dpath_t;

endpackage

// File: rtl/card_hclk_sampler.sv
// Module: registers the host card clock in the clk domain and flags its
// falling edges. Assumes host_clk is synchronous to clk, or slow enough
// that a one-flop sample is acceptable.
module card_hclk_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic host_clk,
    output logic hclk_q,
    output logic hclk_fall
);

    // Purpose: hold last sampled host clock level
    always_ff @(posedge clk) begin
        if (!rst_n) hclk_q <= 1'b0;
        else        hclk_q <= host_clk;
    end

    // Purpose: falling edge is seen when the stored level is high and the new one low
    assign hclk_fall = hclk_q & ~host_clk;

endmodule

// File: rtl/card_chan_ctrl.sv
// Module: per-channel control. It handles the reset hold, clock gating
// and supply code for one channel. Assumes hclk_fall comes from a
// sampler that shares this clk, and that IDX fits in SELW bits.
module card_chan_ctrl
    import card_router_pkg::*;
#(
    parameter int SELW = 1,
    parameter int IDX  = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] chan_sel,
    input  logic            en,
    input  logic            rdy,
    input  logic            vsel,
    input  logic            clkrun,
    input  logic            host_rst,
    input  logic            hclk_q,
    input  logic            hclk_fall,
    output logic            live_q,
    output logic            card_rst,
    output logic            card_clk,
    output logic [VCW-1:0]  vcode
);

    localparam logic [SELW-1:0] MY_IDX = SELW'(IDX);

    logic   selected;
    logic   live;
    logic   rst_q;
    logic   gate_q;
    vcode_t vcode_q;

    assign selected = (chan_sel == MY_IDX);
    assign live     = en & rdy;

    // Purpose: track whether the channel may drive its outputs
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= live;
    end

    // Purpose: reset follows host when selected, holds when deselected, zero when not live
    always_ff @(posedge clk) begin
        if (!rst_n)        rst_q <= 1'b0;
        else if (!live)    rst_q <= 1'b0;
        else if (selected) rst_q <= host_rst;
    end

    // Purpose: clock gate, changed only at host clock falling edges (cleared at once when not live)
    always_ff @(posedge clk) begin
        if (!rst_n)         gate_q <= 1'b0;
        else if (!live)     gate_q <= 1'b0;
        else if (hclk_fall) gate_q <= selected | clkrun;
    end

    // Purpose: supply code from enable and level request
    always_ff @(posedge clk) begin
        if (!rst_n)    vcode_q <= VC_OFF;
        else if (!en)  vcode_q <= VC_OFF;
        else           vcode_q <= vsel ? VC_HIGH : VC_LOW;
    end

    assign card_rst = rst_q;
    assign card_clk = hclk_q & gate_q & live_q;
    assign vcode    = vcode_q;

endmodule

// File: rtl/card_data_path.sv
// Module: wired-AND data router between the host line and the selected
// card line. A direction state records who pulled low first, so the
// copied low is not reflected back. A release state gives the line one
// clock to recover. Assumes line levels are synchronous to clk.
module card_data_path
    import card_router_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int SELW = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] chan_sel,
    input  logic [NCH-1:0]  live_in,
    input  logic [NCH-1:0]  live_q,
    input  logic            host_dat_in,
    input  logic [NCH-1:0]  card_dat_in,
    output logic            host_dat_oe,
    output logic [NCH-1:0]  card_dat_oe
);

    dpath_t          state_q, state_d;
    logic [SELW-1:0] sel_q;
    logic            path_ok;
    logic            card_line;

    assign path_ok   = live_in[chan_sel] && (chan_sel == sel_q);
    assign card_line = card_dat_in[sel_q];

    // Purpose: next direction state from both line levels
    always_comb begin
        state_d = state_q;
        if (!path_ok) begin
            state_d = DP_IDLE;
        end else begin
            unique case (state_q)
                DP_IDLE: begin
                    if (!host_dat_in)    state_d = DP_H2C;
                    else if (!card_line) state_d = DP_C2H;
                end
                DP_H2C:  if (host_dat_in) state_d = DP_REL;
                DP_C2H:  if (card_line)   state_d = DP_REL;
                DP_REL:  state_d = DP_IDLE;
                default: state_d = DP_IDLE;
            endcase
        end
    end

    // Purpose: register direction state and the selection it belongs to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DP_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= chan_sel;
        end
    end

    assign host_dat_oe = (state_q == DP_C2H);

    // Purpose: per-channel drive, forced low when not live
    for (genvar c = 0; c < NCH; c++) begin : g_oe
        localparam logic [SELW-1:0] CI = SELW'(c);
        assign card_dat_oe[c] = ~live_q[c] | ((state_q == DP_H2C) && (sel_q == CI));
    end

endmodule

// File: rtl/dual_card_router.sv
// Module: top of the dual card router. It shares one host clock sampler
// and one data path, and has one control slice per channel. Assumes the
// power sequencer supplies chan_rdy and that clk oversamples host_clk.
module dual_card_router
    import card_router_pkg::*;
#(
    parameter int NCH  = NCH_DEF,
    parameter int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SELW-1:0]   chan_sel,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH-1:0]    chan_rdy,
    input  logic [NCH-1:0]    chan_vsel,
    input  logic [NCH-1:0]    chan_clkrun,
    input  logic              host_clk,
    input  logic              host_rst,
    input  logic              host_dat_in,
    output logic              host_dat_oe,
    output logic [NCH-1:0]    card_clk,
    output logic [NCH-1:0]    card_rst,
    input  logic [NCH-1:0]    card_dat_in,
    output logic [NCH-1:0]    card_dat_oe,
    output logic [VCW*NCH-1:0] card_vcode
);

    logic           hclk_q;
    logic           hclk_fall;
    logic [NCH-1:0] live_q;

    card_hclk_sampler u_hclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_clk  (host_clk),
        .hclk_q    (hclk_q),
        .hclk_fall (hclk_fall)
    );

    // Purpose: one control slice per channel
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        card_chan_ctrl #(.SELW(SELW), .IDX(c)) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .chan_sel  (chan_sel),
            .en        (chan_en[c]),
            .rdy       (chan_rdy[c]),
            .vsel      (chan_vsel[c]),
            .clkrun    (chan_clkrun[c]),
            .host_rst  (host_rst),
            .hclk_q    (hclk_q),
            .hclk_fall (hclk_fall),
            .live_q    (live_q[c]),
            .card_rst  (card_rst[c]),
            .card_clk  (card_clk[c]),
            .vcode     (card_vcode[VCW*c +: VCW])
        );
    end

    card_data_path #(.NCH(NCH), .SELW(SELW)) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_sel    (chan_sel),
        .live_in     (chan_en & chan_rdy),
        .live_q      (live_q),
        .host_dat_in (host_dat_in),
        .card_dat_in (card_dat_in),
        .host_dat_oe (host_dat_oe),
        .card_dat_oe (card_dat_oe)
    );

endmodule

// File: rtl/dual_card_router_chk.sv
// Checker: temporal properties of the router, seen at its ports.
// Attached to every instance of the top module by the bind below.
module dual_card_router_chk #(
    parameter int NCH  = 2,
    parameter int SELW = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SELW-1:0]   chan_sel,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH-1:0]    chan_rdy,
    input logic [NCH-1:0]    chan_vsel,
    input logic [NCH-1:0]    chan_clkrun,
    input logic              host_clk,
    input logic              host_rst,
    input logic              host_dat_oe,
    input logic [NCH-1:0]    card_clk,
    input logic [NCH-1:0]    card_rst,
    input logic [NCH-1:0]    card_dat_oe,
    input logic [2*NCH-1:0]  card_vcode
);

    // R10: no enabled channel means the host line is released
    a_r10_host_released: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(chan_en) == '0)) |-> !host_dat_oe);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [SELW-1:0] CI = SELW'(c);

        // R3: selected live channel follows host reset
        a_r3_rst_follow: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(chan_en[c] && chan_rdy[c] && chan_sel == CI))
            |-> card_rst[c] == $past(host_rst));

        // R4: deselected live channel keeps its reset level
        a_r4_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(chan_en[c] && chan_rdy[c] && chan_sel != CI))
            |-> card_rst[c] == $past(card_rst[c]));

        // R2: deselected live channel releases its data line
        a_r2_desel_release: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(chan_en[c] && chan_rdy[c] && chan_sel != CI))
            |-> !card_dat_oe[c]);

        // R8: channel not live forces its outputs low
        a_r8_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(chan_en[c] && chan_rdy[c]))
            |-> (!card_rst[c] && !card_clk[c] && card_dat_oe[c]));

        // R9: supply code tracks enable and level request
        a_r9_vcode: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> card_vcode[2*c +: 2] ==
                ($past(chan_en[c]) ? ($past(chan_vsel[c]) ? 2'b10 : 2'b01) : 2'b00));

        // R7: card clock high only after host clock was high
        a_r7_clk_source: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && card_clk[c]) |-> $past(host_clk));

        // R7: card clock pulses begin only with a host clock rise
        a_r7_no_short_start: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 2) && $past(rst_n) && $rose(card_clk[c]))
            |-> ($past(host_clk) && !$past(host_clk, 2)));
    end

endmodule

bind dual_card_router dual_card_router_chk #(.NCH(NCH), .SELW(SELW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_sel    (chan_sel),
    .chan_en     (chan_en),
    .chan_rdy    (chan_rdy),
    .chan_vsel   (chan_vsel),
    .chan_clkrun (chan_clkrun),
    .host_clk    (host_clk),
    .host_rst    (host_rst),
    .host_dat_oe (host_dat_oe),
    .card_clk    (card_clk),
    .card_rst    (card_rst),
    .card_dat_oe (card_dat_oe),
    .card_vcode  (card_vcode)
);

// File: tb/dual_card_router_bench.sv
// Bench: sweeps the channel configuration, host clock phases, reset
// hold cases and data directions. Expected values come from the brief.
module dual_card_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HHALF      = 4;
    localparam int NCH        = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [0:0] chan_sel;
    logic [1:0] chan_en, chan_rdy, chan_vsel, chan_clkrun, card_pull;
    logic       host_clk, host_rst, host_pull;
    logic       host_dat_in, host_dat_oe;
    logic [1:0] card_clk, card_rst, card_dat_in, card_dat_oe;
    logic [3:0] card_vcode;
    logic       hclk_seen;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 0;
    int         run_len[2];
    bit         valid[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain line models: low when either side pulls
    assign host_dat_in = ~(host_dat_oe | host_pull);
    assign card_dat_in = ~(card_dat_oe | card_pull);

    always @(posedge clk) hclk_seen <= host_clk;

    dual_card_router u_dual_card_router (
        .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .chan_en(chan_en),
        .chan_rdy(chan_rdy), .chan_vsel(chan_vsel), .chan_clkrun(chan_clkrun),
        .host_clk(host_clk), .host_rst(host_rst), .host_dat_in(host_dat_in),
        .host_dat_oe(host_dat_oe), .card_clk(card_clk), .card_rst(card_rst),
        .card_dat_in(card_dat_in), .card_dat_oe(card_dat_oe), .card_vcode(card_vcode)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Host clock generator, toggled at negedges
    initial begin
        host_clk = 1'b0;
        forever begin
            repeat (HHALF) @(negedge clk);
            host_clk = ~host_clk;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run ended)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; chan_sel = 0; chan_en = 0; chan_rdy = 0; chan_vsel = 0;
        chan_clkrun = 0; card_pull = 0; host_pull = 0; host_rst = 0;
        tick(3);
        // R12: reset state
        chk("R12 card_rst", card_rst, 0);
        chk("R12 card_clk", card_clk, 0);
        chk("R12 host_dat_oe", host_dat_oe, 0);
        chk("R12 card_vcode", card_vcode, 0);
        chk("R12 card_dat_oe", card_dat_oe, 3);
        rst_n = 1;
        tick(2);

        // Sweep: select, enable, clock-run, level request
        for (int cfg = 0; cfg < 128; cfg++) begin
            chan_sel    = cfg[0];
            chan_en     = cfg[2:1];
            chan_rdy    = cfg[2:1];
            chan_clkrun = cfg[4:3];
            chan_vsel   = cfg[6:5];
            tick(24);
            for (int k = 0; k < 16; k++) begin
                for (int c = 0; c < NCH; c++) begin
                    bit want;
                    want = chan_en[c] && ((chan_sel == 1'(c)) || chan_clkrun[c]);
                    chk(!chan_en[c] ? "R8 clk" : (want ? "R5 clk" : "R6 clk"),
                        card_clk[c], int'(hclk_seen & want));
                end
                tick(1);
            end
            for (int c = 0; c < NCH; c++) begin
                chk("R9 vcode", card_vcode[2*c +: 2],
                    chan_en[c] ? (chan_vsel[c] ? 2 : 1) : 0);
                chk(chan_en[c] ? "R2 idle oe" : "R8 oe", card_dat_oe[c], int'(!chan_en[c]));
            end
            if (chan_en == 0) chk("R10 host oe", host_dat_oe, 0);
        end

        // R6/R7: switch selection at every host clock phase
        chan_vsel = 0;
        for (int ph = 0; ph < 2*HHALF; ph++) begin
            chan_sel = 0; chan_en = 3; chan_rdy = 3; chan_clkrun = 0;
            tick(24);
            for (int c = 0; c < NCH; c++) begin
                run_len[c] = 0; valid[c] = 0;
            end
            for (int k = 0; k < 48; k++) begin
                if (k == ph + 4) chan_sel = 1;
                tick(1);
                for (int c = 0; c < NCH; c++) begin
                    if (card_clk[c]) begin
                        if (valid[c]) run_len[c]++;
                    end else begin
                        if (valid[c] && run_len[c] > 0) chk("R7 pulse", run_len[c], HHALF);
                        run_len[c] = 0;
                        valid[c] = 1;
                    end
                end
                if (k >= ph + 4 + 4*HHALF + 1) chk("R6 stop", card_clk[0], 0);
            end
        end

        // R3/R4: reset follow and hold
        for (int v = 0; v < 2; v++) begin
            chan_sel = 0; chan_en = 3; chan_rdy = 3;
            for (int i = 0; i < 6; i++) begin
                host_rst = ((i * 5 + v) % 3) == 0;
                tick(1);
                chk("R3 follow", card_rst[0], int'(host_rst));
            end
            host_rst = 1'(v);
            tick(1);
            chan_sel = 1;
            tick(1);
            for (int i = 0; i < 6; i++) begin
                host_rst = ~host_rst;
                tick(1);
                chk("R4 hold", card_rst[0], v);
                chk("R3 follow B", card_rst[1], int'(host_rst));
            end
            host_rst = 1'(1 - v);
            chan_sel = 0;
            tick(1);
            chk("R4 resume", card_rst[0], 1 - v);
        end

        // R1/R2/R11: data directions for each selection
        host_rst = 0;
        for (int s = 0; s < 2; s++) begin
            chan_sel = 1'(s); chan_en = 3; chan_rdy = 3;
            tick(2);
            host_pull = 1;
            tick(1);
            chk("R1 host to card", card_dat_oe[s], 1);
            chk("R2 other idle", card_dat_oe[1-s], 0);
            tick(2);
            chk("R11 no echo", host_dat_oe, 0);
            chk("R1 held", card_dat_oe[s], 1);
            host_pull = 0;
            tick(2);
            chk("R11 released", card_dat_oe[s], 0);
            chk("R11 host idle", host_dat_oe, 0);
            card_pull[s] = 1;
            tick(1);
            chk("R1 card to host", host_dat_oe, 1);
            tick(2);
            chk("R11 no echo card", card_dat_oe[s], 0);
            card_pull[s] = 0;
            tick(2);
            chk("R1 host release", host_dat_oe, 0);
            card_pull[1-s] = 1;
            tick(3);
            chk("R2 isolated", host_dat_oe, 0);
            card_pull[1-s] = 0;
            tick(1);
            host_pull = 1; card_pull[s] = 1;
            tick(1);
            chk("R11 host wins card", card_dat_oe[s], 1);
            chk("R11 host wins host", host_dat_oe, 0);
            host_pull = 0; card_pull[s] = 0;
            tick(3);
            chk("R11 idle again", host_dat_oe, 0);
        end

        // R10/R8: both channels disabled
        chan_en = 0; chan_rdy = 0; card_pull = 3;
        tick(3);
        chk("R10 host released", host_dat_oe, 0);
        chk("R8 both forced", card_dat_oe, 3);
        card_pull = 0;

        // R8/R9: enabled but not ready
        chan_sel = 0; chan_en = 3; chan_rdy = 2'b10; chan_vsel = 2'b01; host_rst = 1;
        tick(20);
        chk("R8 rst low", card_rst[0], 0);
        chk("R8 oe forced", card_dat_oe[0], 1);
        chk("R8 clk low", card_clk[0], 0);
        chk("R9 code w/o ready", card_vcode[1:0], 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule